// File: doc/BRIEF.md
# Edge/Level Interrupt Input Conditioner

This block is the input stage of an eight-input interrupt controller. A source does not drive a wire into it. Instead it sends requests: raise a pin, drop a pin, or raise and drop it in one go (a pulse). Each pin keeps a saturating count of raises that have not yet been dropped. A trigger-mode register chooses, per pin, whether the pin behaves as edge or level. From the count and the mode the block derives one-cycle set and clear strobes for the controller's request register. It does not hold that register itself.

The trigger-mode register can be written and read back. A fixed write mask, given as a parameter, keeps selected pins in edge mode permanently. The controller core also drives an acceptance hook: when the core takes a pin, the block issues a clear strobe for that pin if no raise is outstanding on it. Counter overflow and underflow are each flagged as a strobe and tallied in a saturating statistic counter.

Only one request is handled per cycle, and requests are ignored while the controller reports not ready. Priority resolution belongs to the core and is not part of this block.

Top module: `irq_input_conditioner`

## Requirements
- R1: After reset all pin counts are zero, the trigger-mode readback is 0, every strobe and error output is 0, busy is 0 and both statistic counters are 0.
- R2: A raise request (req_op = 2'b01) increments the pin's count. When the count goes from 0 to 1, bit req_pin of irr_set is 1 in the cycle after the request.
- R3: A raise on a pin whose count is at its maximum (2^CNT_W-1) leaves the count unchanged and gives a one-cycle err_ovf strobe in the cycle after the request.
- R4: A drop request (req_op = 2'b10) decrements the count. A drop at count zero leaves the count at zero and gives a one-cycle err_unf strobe.
- R5: For a pin in level mode (its trigger-mode bit is 1), any raise or drop that leaves the count nonzero strobes irr_set for that pin. A drop from 1 to 0 strobes irr_clr for that pin.
- R6: For a pin in edge mode (bit 0), a drop from 1 to 0 produces no irr_clr strobe, and a raise from a nonzero count produces no irr_set strobe.
- R7: A pulse request (req_op = 2'b11) performs a raise in the first cycle and a drop on the same pin in the next cycle, with busy high during that second cycle. If the raise overflowed, the drop is skipped and busy stays low.
- R8: A write to the trigger-mode register stores wdata AND WR_MASK, and elc_rdata shows the stored value from the cycle after the write.
- R9: While ready is 0, raise, drop and pulse requests have no effect: no strobes, no errors and no count change.
- R10: When accept_valid is 1 and the count of accept_pin is zero, irr_clr for that pin is strobed in the next cycle. If the count is nonzero, no clear is strobed. The count checked is the value before any request in the same cycle.
- R11: ovf_count and unf_count add one for each err_ovf or err_unf strobe and hold at 2^STAT_W-1.
- R12: A request presented while busy is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready | input | 1 | Controller initialised; requests are ignored while 0 |
| req_op | input | 2 | 00 idle, 01 raise, 10 drop, 11 pulse |
| req_pin | input | 3 | Pin addressed by req_op |
| busy | output | 1 | Second (drop) cycle of a pulse in progress |
| accept_valid | input | 1 | Core has accepted accept_pin |
| accept_pin | input | 3 | Pin accepted by the core |
| elc_wr | input | 1 | Write strobe for the trigger-mode register |
| elc_wdata | input | 8 | Trigger-mode write data, 1 = level |
| elc_rdata | output | 8 | Trigger-mode register contents |
| irr_set | output | 8 | Per-pin request-set strobes |
| irr_clr | output | 8 | Per-pin request-clear strobes |
| err_ovf | output | 1 | Raise hit a saturated count |
| err_unf | output | 1 | Drop hit a zero count |
| ovf_count | output | STAT_W | Saturating overflow tally |
| unf_count | output | STAT_W | Saturating underflow tally |

## Verification
The bench builds the block with CNT_W = 2, so a pin saturates after three raises. This brings overflow, and pulses issued at overflow, within a few cycles. STAT_W = 2 lets both statistic counters reach their ceiling of 3 and be seen holding there. WR_MASK = 8'hDE puts forced-edge pins (0 and 5) next to writable level pins, so edge and level behaviour can be compared on the same instance.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    OP_NONE     = 2'b00,
    OP_RAISE    = 2'b01,
    OP_DROP     = 2'b10,
    OP_PULSE    = 2'b11
  } req_op_e;
endpackage

// File: rtl/irqc_pin_counter.sv
module irqc_pin_counter #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  input  logic level,
  input  logic accept,
  output logic set_nxt,
  output logic clr_nxt,
  output logic ovf,
  output logic unf
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic zero, full;

  assign zero = (cnt_q == '0);
  assign full = (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !full)      cnt_d = cnt_q + CNT_ONE;
    else if (dec && !zero) cnt_d = cnt_q - CNT_ONE;
  end

  assign ovf = inc & full;
  assign unf = dec & zero;

  always_comb begin
    set_nxt = (inc | dec) & ((zero && cnt_d == CNT_ONE) || (cnt_d != '0 && level));
    clr_nxt = (dec & level & (cnt_q == CNT_ONE)) | (accept & zero & ~set_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/irqc_trigger_reg.sv
module irqc_trigger_reg #(
  parameter int          PINS    = 8,
  parameter logic [PINS-1:0] WR_MASK = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] mode
);
  always_ff @(posedge clk) begin
    if (rst)     mode <= '0;
    else if (wr) mode <= wdata & WR_MASK;
  end
endmodule

// File: rtl/irqc_sat_stat.sv
module irqc_sat_stat #(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bump,
  output logic [STAT_W-1:0] count
);
  localparam logic [STAT_W-1:0] STAT_ONE = STAT_W'(1);
  always_ff @(posedge clk) begin
    if (rst)                        count <= '0;
    else if (bump && count != '1)   count <= count + STAT_ONE;
  end
endmodule

// File: rtl/irq_input_conditioner.sv
module irq_input_conditioner #(
  parameter int         CNT_W   = 8,
  parameter int         STAT_W  = 16,
  parameter logic [7:0] WR_MASK = 8'hF8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ready,
  input  logic [1:0]        req_op,
  input  logic [2:0]        req_pin,
  output logic              busy,
  input  logic              accept_valid,
  input  logic [2:0]        accept_pin,
  input  logic              elc_wr,
  input  logic [7:0]        elc_wdata,
  output logic [7:0]        elc_rdata,
  output logic [7:0]        irr_set,
  output logic [7:0]        irr_clr,
  output logic              err_ovf,
  output logic              err_unf,
  output logic [STAT_W-1:0] ovf_count,
  output logic [STAT_W-1:0] unf_count
);
  import irqc_pkg::*;

  localparam int PINS  = 8;
  localparam int PIN_W = $clog2(PINS);

  req_op_e          op;
  logic             take, do_inc, do_dec, start_pulse;
  logic [PIN_W-1:0] pend_pin_q, dec_pin;
  logic [PINS-1:0]  set_vec, clr_vec, ovf_vec, unf_vec, mode;

  assign op          = req_op_e'(req_op);
  assign take        = ready & ~busy & (op != OP_NONE);
  assign do_inc      = take & (op == OP_RAISE || op == OP_PULSE);
  assign do_dec      = busy | (take & (op == OP_DROP));
  assign dec_pin     = busy ? pend_pin_q : req_pin;
  assign start_pulse = take & (op == OP_PULSE) & ~(|ovf_vec);

  irqc_trigger_reg #(.PINS(PINS), .WR_MASK(WR_MASK)) u_mode (
    .clk(clk), .rst(rst), .wr(elc_wr), .wdata(elc_wdata), .mode(mode)
  );
  assign elc_rdata = mode;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    irqc_pin_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .inc    (do_inc & (req_pin == PIN_W'(i))),
      .dec    (do_dec & (dec_pin == PIN_W'(i))),
      .level  (mode[i]),
      .accept (accept_valid & (accept_pin == PIN_W'(i))),
      .set_nxt(set_vec[i]),
      .clr_nxt(clr_vec[i]),
      .ovf    (ovf_vec[i]),
      .unf    (unf_vec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      pend_pin_q <= '0;
      irr_set    <= '0;
      irr_clr    <= '0;
      err_ovf    <= 1'b0;
      err_unf    <= 1'b0;
    end else begin
      busy       <= start_pulse;
      if (start_pulse) pend_pin_q <= req_pin;
      irr_set    <= set_vec;
      irr_clr    <= clr_vec;
      err_ovf    <= |ovf_vec;
      err_unf    <= |unf_vec;
    end
  end

  irqc_sat_stat #(.STAT_W(STAT_W)) u_ovf_stat (
    .clk(clk), .rst(rst), .bump(|ovf_vec), .count(ovf_count)
  );
  irqc_sat_stat #(.STAT_W(STAT_W)) u_unf_stat (
    .clk(clk), .rst(rst), .bump(|unf_vec), .count(unf_count)
  );
endmodule

// File: rtl/irq_input_conditioner_chk.sv
module irq_input_conditioner_chk #(
  parameter int         STAT_W  = 16,
  parameter logic [7:0] WR_MASK = 8'hF8
) (
  input logic              clk,
  input logic              rst,
  input logic              ready,
  input logic [1:0]        req_op,
  input logic              busy,
  input logic [7:0]        elc_rdata,
  input logic [7:0]        irr_set,
  input logic [7:0]        irr_clr,
  input logic              err_ovf,
  input logic              err_unf,
  input logic [STAT_W-1:0] ovf_count,
  input logic [STAT_W-1:0] unf_count
);
  AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (rst)
    (irr_set & irr_clr) == 8'h00); // R5
  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (rst)
    !(err_ovf && err_unf)); // R3
  AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy); // R7
  AST_BUSY_FROM_PULSE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_op) == 2'b11); // R7
  AST_MODE_MASK: assert property (@(posedge clk) disable iff (rst)
    (elc_rdata & ~WR_MASK) == 8'h00); // R8
  AST_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (!ready && !busy && req_op != 2'b00) |=> (irr_set == 8'h00 && !err_ovf && !err_unf)); // R9
  AST_OVF_STAT: assert property (@(posedge clk) disable iff (rst)
    !$stable(ovf_count) |-> err_ovf); // R11
  AST_UNF_STAT: assert property (@(posedge clk) disable iff (rst)
    !$stable(unf_count) |-> err_unf); // R11
endmodule

bind irq_input_conditioner irq_input_conditioner_chk #(
  .STAT_W(STAT_W), .WR_MASK(WR_MASK)
) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .req_op(req_op), .busy(busy),
  .elc_rdata(elc_rdata), .irr_set(irr_set), .irr_clr(irr_clr),
  .err_ovf(err_ovf), .err_unf(err_unf),
  .ovf_count(ovf_count), .unf_count(unf_count)
);

// File: tb/tb_irq_input_conditioner.sv
module tb_irq_input_conditioner;
  localparam int STAT_W = 2;

  logic clk = 0, rst = 1, ready = 1, accept_valid = 0, elc_wr = 0;
  logic [1:0] req_op = 0;
  logic [2:0] req_pin = 0, accept_pin = 0;
  logic [7:0] elc_wdata = 0;
  logic busy, err_ovf, err_unf;
  logic [7:0] elc_rdata, irr_set, irr_clr;
  logic [STAT_W-1:0] ovf_count, unf_count;

  int checks = 0, errors = 0;
  int exp_ovf = 0, exp_unf = 0;

  always #4 clk = ~clk;

  irq_input_conditioner #(.CNT_W(2), .STAT_W(STAT_W), .WR_MASK(8'hDE)) dut (
    .clk(clk), .rst(rst), .ready(ready), .req_op(req_op), .req_pin(req_pin),
    .busy(busy), .accept_valid(accept_valid), .accept_pin(accept_pin),
    .elc_wr(elc_wr), .elc_wdata(elc_wdata), .elc_rdata(elc_rdata),
    .irr_set(irr_set), .irr_clr(irr_clr), .err_ovf(err_ovf), .err_unf(err_unf),
    .ovf_count(ovf_count), .unf_count(unf_count)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one request for one cycle; outputs are valid on return
  task automatic op(input logic [1:0] o, input logic [2:0] p);
    @(negedge clk); req_op = o; req_pin = p;
    @(negedge clk); req_op = 2'b00;
    if (o == 2'b01 && err_ovf) exp_ovf++;
    if (o == 2'b10 && err_unf) exp_unf++;
  endtask

  task automatic expect_out(string tag, int s, int c, int ov, int un);
    chk({tag, " set"}, irr_set, s);
    chk({tag, " clr"}, irr_clr, c);
    chk({tag, " ovf"}, err_ovf, ov);
    chk({tag, " unf"}, err_unf, un);
  endtask

  task automatic t_reset();
    expect_out("R1 reset", 0, 0, 0, 0);
    chk("R1 busy", busy, 0);
    chk("R1 mode", elc_rdata, 0);
    chk("R1 ovf_count", ovf_count, 0);
    chk("R1 unf_count", unf_count, 0);
  endtask

  task automatic t_edge();
    op(2'b01, 3); expect_out("R2 first raise", 8'h08, 0, 0, 0);
    op(2'b01, 3); expect_out("R6 second raise", 0, 0, 0, 0);
    op(2'b10, 3); expect_out("R6 drop 2-1", 0, 0, 0, 0);
    op(2'b10, 3); expect_out("R6 drop 1-0", 0, 0, 0, 0);
    op(2'b10, 3); expect_out("R4 drop at zero", 0, 0, 0, 1);
    op(2'b01, 3); expect_out("R4 count stayed zero", 8'h08, 0, 0, 0);
    op(2'b10, 3);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 3; i++) op(2'b01, 4);
    op(2'b01, 4); expect_out("R3 raise at max", 0, 0, 1, 0);
    for (int i = 0; i < 3; i++) begin
      op(2'b10, 4); chk("R3 count held at max", err_unf, 0);
    end
    op(2'b10, 4); expect_out("R3 empty after max drops", 0, 0, 0, 1);
  endtask

  task automatic t_level();
    @(negedge clk); elc_wr = 1; elc_wdata = 8'hFF;
    @(negedge clk); elc_wr = 0;
    chk("R8 masked write", elc_rdata, 8'hDE);
    op(2'b01, 1); expect_out("R5 level raise 0-1", 8'h02, 0, 0, 0);
    op(2'b01, 1); expect_out("R5 level raise 1-2", 8'h02, 0, 0, 0);
    op(2'b10, 1); expect_out("R5 level drop 2-1", 8'h02, 0, 0, 0);
    op(2'b10, 1); expect_out("R5 level drop 1-0", 0, 8'h02, 0, 0);
    op(2'b01, 0); op(2'b10, 0);
    expect_out("R8 forced-edge pin 0", 0, 0, 0, 0);
  endtask

  task automatic t_pulse();
    @(negedge clk); req_op = 2'b11; req_pin = 2;
    @(negedge clk); req_op = 2'b01; req_pin = 5; // offered while busy
    expect_out("R7 pulse raise", 8'h04, 0, 0, 0);
    chk("R7 busy", busy, 1);
    @(negedge clk); req_op = 2'b00;
    expect_out("R7 pulse drop", 0, 8'h04, 0, 0);
    chk("R7 busy done", busy, 0);
    op(2'b01, 5); expect_out("R12 request during busy ignored", 8'h20, 0, 0, 0);
    op(2'b10, 5);
    for (int i = 0; i < 3; i++) op(2'b01, 0);
    @(negedge clk); req_op = 2'b11; req_pin = 0;
    @(negedge clk); req_op = 2'b00;
    exp_ovf++;
    chk("R7 pulse overflow err", err_ovf, 1);
    chk("R7 no drop after overflow", busy, 0);
    @(negedge clk);
    chk("R7 skipped drop", err_unf | irr_clr, 0);
    for (int i = 0; i < 3; i++) begin
      op(2'b10, 0); chk("R7 count still max", err_unf, 0);
    end
  endtask

  task automatic t_ready();
    ready = 0;
    op(2'b01, 3); expect_out("R9 raise while not ready", 0, 0, 0, 0);
    op(2'b10, 3); expect_out("R9 drop while not ready", 0, 0, 0, 0);
    ready = 1;
    op(2'b01, 3); expect_out("R9 count untouched", 8'h08, 0, 0, 0);
  endtask

  task automatic t_accept();
    @(negedge clk); accept_valid = 1; accept_pin = 3;
    @(negedge clk); accept_valid = 0;
    chk("R10 accept nonzero", irr_clr, 0);
    op(2'b10, 3);
    @(negedge clk); accept_valid = 1; accept_pin = 3;
    @(negedge clk); accept_valid = 0;
    chk("R10 accept zero", irr_clr, 8'h08);
  endtask

  task automatic t_stats();
    chk("R11 ovf tally", ovf_count, exp_ovf);
    chk("R11 unf tally", unf_count, exp_unf);
    for (int i = 0; i < 3; i++) op(2'b10, 6);
    for (int i = 0; i < 3; i++) op(2'b01, 6);
    for (int i = 0; i < 3; i++) op(2'b01, 6);
    chk("R11 unf saturates", unf_count, 3);
    chk("R11 ovf saturates", ovf_count, 3);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset(); t_edge(); t_saturate(); t_level();
        t_pulse(); t_ready(); t_accept(); t_stats();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule